// File: doc/BRIEF.md
# Interlaced Vertical Timing Generator

This block produces the vertical timing outputs of a video raster: vertical sync, vertical blanking and a field flag. It counts lines on a one-cycle line-rate enable and decodes each output from the current line number and a set of programmable line numbers. The programmable values are the frame length, the two sync start lines, the sync length, the two active-video windows, a reference offset, the scan mode and three polarity bits.

The generator either free-runs at the programmed frame length or, in locked mode, aligns its line counter to the rising edge of an external reference vertical pulse. On that edge the counter loads a programmable offset taken modulo the frame length. A lock-loss flag is raised when locked mode is on and more than one frame of lines passes with no reference edge.

All configuration is written through a write-enable/address/data port into a staging bank. The staged values move into the working set only at the frame boundary, so a frame never mixes old and new settings.

Top module: `vtiming_gen`

## Requirements
- R1: Once reset is released, with default settings, vsync_o is 1, vblank_o is 1, field_o is 0 and lock_lost_o is 0, and the line counter is at line 0.
- R2: Each line_en pulse advances the line counter by one. A pulse on line TOTAL-1 returns it to 0, and TOTAL may be odd. The outputs show the new line one clock after the counter changes.
- R3: Vertical sync is active on lines VS1 to VS1+VSLEN-1, and in interlaced mode also on lines VS2 to VS2+VSLEN-1. With polarity bit 0 clear (the reset value) active is low, and with bit 0 set active is high.
- R4: vblank_o is 1 on every line outside the active windows [ACT1S, ACT1E) and, when interlaced, [ACT2S, ACT2E). It is 0 inside them. Polarity bit 1 inverts it.
- R5: In interlaced mode the field flag becomes 1 on line VS1, becomes 0 on line VS2, and otherwise keeps its value. It therefore changes only where a vsync pulse begins. Polarity bit 2 inverts field_o.
- R6: In progressive mode (mode bit 0 clear) the field flag is 0 on every line, and the second sync and the second active window are not produced.
- R7: Register writes go to a staging bank and take effect at the next frame boundary. A mid-frame write leaves the outputs unchanged. Addresses: 0 TOTAL, 1 VS1, 2 VS2, 3 VSLEN, 4 ACT1S, 5 ACT1E, 6 ACT2S, 7 ACT2E, 8 OFFSET, 9 mode (bit 0 interlaced, bit 1 locked), 10 polarity (bit 0 vsync active high, bit 1 blanking invert, bit 2 field invert).
- R8: In locked mode, a rising edge on ref_vpulse loads the line counter with OFFSET mod TOTAL, and this takes priority over line_en.
- R9: With locked mode off, ref_vpulse has no effect on the line counter.
- R10: In locked mode, lock_lost_o goes to 1 on the line_en pulse that makes the count of lines since the last reference edge exceed TOTAL. A reference edge clears it, and it is held at 0 while locked mode is off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_en | input | 1 | One-cycle pulse per video line |
| ref_vpulse | input | 1 | External reference vertical pulse, rising-edge sensitive |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 4 | Configuration register address |
| cfg_wdata | input | 11 | Configuration write data |
| vsync_o | output | 1 | Vertical sync |
| vblank_o | output | 1 | Vertical blanking |
| field_o | output | 1 | Field flag |
| lock_lost_o | output | 1 | Reference missing while locked |

## Verification
A full interlaced frame with an odd line count is walked twice against a per-line table. This tells apart the two sync pulses, the two active windows and the field flag, whose edges fall on different lines. The same timing is then run with all polarity bits inverted, then in progressive mode, and then locked to a reference edge with an offset larger than the frame. These separate a polarity fault from a window fault, show what progressive mode suppresses, and show that the modulo is applied. A mid-frame write, a reference edge while unlocked, and a count of exactly TOTAL versus TOTAL+1 lines without a reference exercise the staging, the ignore case and the lock-loss threshold.

// File: rtl/vtg_pkg.sv
package vtg_pkg;

    localparam int LW = 11;
    localparam int AW = 4;

    typedef logic [LW-1:0] line_t;
    typedef logic [LW:0]   line_ext_t;

    localparam line_ext_t ONE_EXT = line_ext_t'(1);

    typedef enum logic [AW-1:0] {
        A_TOTAL  = 4'd0,
        A_VS1    = 4'd1,
        A_VS2    = 4'd2,
        A_VSLEN  = 4'd3,
        A_ACT1S  = 4'd4,
        A_ACT1E  = 4'd5,
        A_ACT2S  = 4'd6,
        A_ACT2E  = 4'd7,
        A_OFFSET = 4'd8,
        A_MODE   = 4'd9,
        A_POL    = 4'd10
    } reg_addr_e;

    // settings used by the line counter
    typedef struct packed {
        line_t total;
        line_t offset;
        logic  lock_en;
    } vtg_frame_t;

    // settings used by the output decoder
    typedef struct packed {
        line_t vs1_start;
        line_t vs2_start;
        line_t vs_len;
        line_t act1_start;
        line_t act1_end;
        line_t act2_start;
        line_t act2_end;
        logic  interlace;
        logic  vs_hi;
        logic  vb_inv;
        logic  fld_inv;
    } vtg_shape_t;

    typedef struct packed {
        vtg_frame_t frame;
        vtg_shape_t shape;
    } vtg_cfg_t;

    localparam vtg_cfg_t CFG_DEFAULT = '{
        frame: '{total: 11'd525, offset: 11'd0, lock_en: 1'b0},
        shape: '{vs1_start: 11'd3, vs2_start: 11'd265, vs_len: 11'd3,
                 act1_start: 11'd20, act1_end: 11'd263,
                 act2_start: 11'd283, act2_end: 11'd525,
                 interlace: 1'b1, vs_hi: 1'b0, vb_inv: 1'b0, fld_inv: 1'b0}
    };

    function automatic logic in_span(line_t ln, line_t first, line_t stop);
        return (ln >= first) && (ln < stop);
    endfunction

    function automatic logic in_len(line_t ln, line_t start, line_t len);
        line_ext_t stop;
        stop = {1'b0, start} + {1'b0, len};
        return ({1'b0, ln} >= {1'b0, start}) && ({1'b0, ln} < stop);
    endfunction

    function automatic line_t wrap_offset(line_t off, line_t tot);
        return (tot == '0) ? '0 : (off % tot);
    endfunction

endpackage

// File: rtl/vtg_regs.sv
module vtg_regs
    import vtg_pkg::*;
#(
    parameter vtg_cfg_t CFG_INIT = CFG_DEFAULT
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            cfg_we,
    input  logic [AW-1:0]   cfg_addr,
    input  logic [LW-1:0]   cfg_wdata,
    input  logic            frame_start,
    output vtg_cfg_t        cfg_act
);

    vtg_cfg_t cfg_stage;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_stage <= CFG_INIT;
        end else if (cfg_we) begin
            case (cfg_addr)
                A_TOTAL:  cfg_stage.frame.total      <= cfg_wdata;
                A_VS1:    cfg_stage.shape.vs1_start  <= cfg_wdata;
                A_VS2:    cfg_stage.shape.vs2_start  <= cfg_wdata;
                A_VSLEN:  cfg_stage.shape.vs_len     <= cfg_wdata;
                A_ACT1S:  cfg_stage.shape.act1_start <= cfg_wdata;
                A_ACT1E:  cfg_stage.shape.act1_end   <= cfg_wdata;
                A_ACT2S:  cfg_stage.shape.act2_start <= cfg_wdata;
                A_ACT2E:  cfg_stage.shape.act2_end   <= cfg_wdata;
                A_OFFSET: cfg_stage.frame.offset     <= cfg_wdata;
                A_MODE: begin
                    cfg_stage.shape.interlace <= cfg_wdata[0];
                    cfg_stage.frame.lock_en   <= cfg_wdata[1];
                end
                A_POL: begin
                    cfg_stage.shape.vs_hi   <= cfg_wdata[0];
                    cfg_stage.shape.vb_inv  <= cfg_wdata[1];
                    cfg_stage.shape.fld_inv <= cfg_wdata[2];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_act <= CFG_INIT;
        end else if (frame_start) begin
            cfg_act <= cfg_stage;
        end
    end

    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (rst)
        !frame_start |=> (cfg_act == $past(cfg_act))); // R7

endmodule

// File: rtl/vtg_line_counter.sv
module vtg_line_counter
    import vtg_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        line_en,
    input  logic        ref_vpulse,
    input  vtg_frame_t  frm,
    output line_t       line_q,
    output logic        frame_start,
    output logic        lock_lost
);

    logic      ref_d;
    logic      ref_load;
    logic      at_last;
    line_ext_t since_q;
    line_ext_t since_inc;
    line_ext_t total_ext;

    assign total_ext   = {1'b0, frm.total};
    assign ref_load    = frm.lock_en && ref_vpulse && !ref_d;
    assign at_last     = ({1'b0, line_q} + ONE_EXT) >= total_ext;
    assign frame_start = line_en && !ref_load && at_last;
    assign since_inc   = since_q + ONE_EXT;

    always_ff @(posedge clk) begin
        if (rst) begin
            line_q <= '0;
            ref_d  <= 1'b0;
        end else begin
            ref_d <= ref_vpulse;
            if (ref_load) begin
                line_q <= wrap_offset(frm.offset, frm.total);
            end else if (line_en) begin
                line_q <= at_last ? '0 : (line_q + line_t'(1));
            end
        end
    end

    // lines since the last reference edge, saturating just above one frame
    always_ff @(posedge clk) begin
        if (rst) begin
            since_q   <= '0;
            lock_lost <= 1'b0;
        end else begin
            if (ref_load) begin
                since_q <= '0;
            end else if (line_en && (since_q <= total_ext)) begin
                since_q <= since_inc;
            end
            if (!frm.lock_en) begin
                lock_lost <= 1'b0;
            end else if (ref_load) begin
                lock_lost <= 1'b0;
            end else if (line_en && (since_inc > total_ext)) begin
                lock_lost <= 1'b1;
            end
        end
    end

    AST_LINE_RANGE: assert property (@(posedge clk) disable iff (rst)
        (frm.total != '0) |-> (line_q < frm.total)); // R2

    AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (rst)
        (line_en && !ref_load && ({1'b0, line_q} + ONE_EXT == total_ext))
        |=> (line_q == '0)); // R2

    AST_REF_LOAD: assert property (@(posedge clk) disable iff (rst)
        (frm.lock_en && ref_vpulse && !ref_d)
        |=> (line_q == $past(wrap_offset(frm.offset, frm.total)))); // R8

    AST_REF_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (!frm.lock_en && !line_en) |=> (line_q == $past(line_q))); // R9

    AST_LOST_OFF: assert property (@(posedge clk) disable iff (rst)
        !frm.lock_en |=> !lock_lost); // R10

endmodule

// File: rtl/vtg_decode.sv
module vtg_decode
    import vtg_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  line_t       line_q,
    input  vtg_shape_t  shp,
    output logic        vsync_o,
    output logic        vblank_o,
    output logic        field_o
);

    logic f1_q;
    logic vs_first;
    logic vs_second;
    logic vs_act;
    logic video_act;
    logic field_now;

    always_comb begin
        vs_first  = in_len(line_q, shp.vs1_start, shp.vs_len);
        vs_second = shp.interlace && in_len(line_q, shp.vs2_start, shp.vs_len);
        vs_act    = vs_first || vs_second;
        video_act = in_span(line_q, shp.act1_start, shp.act1_end) ||
                    (shp.interlace && in_span(line_q, shp.act2_start, shp.act2_end));
        if (!shp.interlace) begin
            field_now = 1'b0;
        end else if (line_q == shp.vs1_start) begin
            field_now = 1'b1;
        end else if (line_q == shp.vs2_start) begin
            field_now = 1'b0;
        end else begin
            field_now = f1_q;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            f1_q     <= 1'b0;
            vsync_o  <= 1'b1;
            vblank_o <= 1'b1;
            field_o  <= 1'b0;
        end else begin
            f1_q     <= field_now;
            vsync_o  <= shp.vs_hi ? vs_act : !vs_act;
            vblank_o <= (!video_act) ^ shp.vb_inv;
            field_o  <= field_now ^ shp.fld_inv;
        end
    end

    AST_FIELD_AT_VS: assert property (@(posedge clk) disable iff (rst)
        ((field_o != $past(field_o)) && $past(shp.interlace) && $past(shp.interlace, 2) &&
         ($past(shp.fld_inv) == $past(shp.fld_inv, 2)) && ($past(shp.vs_len) != '0))
        |-> (vsync_o == $past(shp.vs_hi))); // R5

    AST_PROG_FIELD: assert property (@(posedge clk) disable iff (rst)
        !shp.interlace |=> (field_o == $past(shp.fld_inv))); // R6

endmodule

// File: rtl/vtiming_gen.sv
module vtiming_gen #(
    parameter vtg_pkg::vtg_cfg_t CFG_INIT = vtg_pkg::CFG_DEFAULT
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      line_en,
    input  logic                      ref_vpulse,
    input  logic                      cfg_we,
    input  logic [vtg_pkg::AW-1:0]    cfg_addr,
    input  logic [vtg_pkg::LW-1:0]    cfg_wdata,
    output logic                      vsync_o,
    output logic                      vblank_o,
    output logic                      field_o,
    output logic                      lock_lost_o
);

    vtg_pkg::vtg_cfg_t cfg_act;
    vtg_pkg::line_t    line_q;
    logic              frame_start;

    vtg_regs #(.CFG_INIT(CFG_INIT)) i_regs (
        .clk         (clk),
        .rst         (rst),
        .cfg_we      (cfg_we),
        .cfg_addr    (cfg_addr),
        .cfg_wdata   (cfg_wdata),
        .frame_start (frame_start),
        .cfg_act     (cfg_act)
    );

    vtg_line_counter i_count (
        .clk         (clk),
        .rst         (rst),
        .line_en     (line_en),
        .ref_vpulse  (ref_vpulse),
        .frm         (cfg_act.frame),
        .line_q      (line_q),
        .frame_start (frame_start),
        .lock_lost   (lock_lost_o)
    );

    vtg_decode i_decode (
        .clk      (clk),
        .rst      (rst),
        .line_q   (line_q),
        .shp      (cfg_act.shape),
        .vsync_o  (vsync_o),
        .vblank_o (vblank_o),
        .field_o  (field_o)
    );

    AST_RESET_OUTS: assert property (@(posedge clk)
        $past(rst) && rst |=> (vsync_o && vblank_o && !field_o && !lock_lost_o)); // R1

endmodule

// File: tb/test_vtiming_gen.sv
module test_vtiming_gen;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        line_en = 1'b0;
    logic        ref_vpulse = 1'b0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_addr = '0;
    logic [10:0] cfg_wdata = '0;
    logic        vsync_o, vblank_o, field_o, lock_lost_o;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    vtiming_gen i_vtiming_gen (
        .clk(clk), .rst(rst), .line_en(line_en), .ref_vpulse(ref_vpulse),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .vsync_o(vsync_o), .vblank_o(vblank_o), .field_o(field_o),
        .lock_lost_o(lock_lost_o)
    );

    // expected {vsync, vblank, field} per line, interlaced, TOTAL=11,
    // VS1=1 VS2=6 VSLEN=2, active [3,5) and [8,10), default polarity
    localparam logic [2:0] EXP_TBL [11] = '{
        3'b110, 3'b011, 3'b011, 3'b101, 3'b101, 3'b111,
        3'b010, 3'b010, 3'b100, 3'b100, 3'b110
    };

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [10:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic pulse(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk); line_en = 1'b1;
            @(negedge clk); line_en = 1'b0;
            @(negedge clk);
        end
    endtask

    task automatic ref_edge();
        @(negedge clk); ref_vpulse = 1'b1;
        @(negedge clk); ref_vpulse = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", "vsync", vsync_o, 1'b1);
        chk("R1", "vblank", vblank_o, 1'b1);
        chk("R1", "field", field_o, 1'b0);
        chk("R1", "lock_lost", lock_lost_o, 1'b0);

        // staged interlaced timing, offset 14 (mod 11 = 3)
        wr(4'd0, 11'd11); wr(4'd1, 11'd1); wr(4'd2, 11'd6); wr(4'd3, 11'd2);
        wr(4'd4, 11'd3);  wr(4'd5, 11'd5); wr(4'd6, 11'd8); wr(4'd7, 11'd10);
        wr(4'd8, 11'd14); wr(4'd9, 11'd1); wr(4'd10, 11'd0);
        pulse(524);

        // table walk over two frames: R2 R3 R4 R5
        for (int i = 0; i < 22; i++) begin
            pulse(1);
            chk("R3", $sformatf("vsync line %0d", i % 11), vsync_o, EXP_TBL[i % 11][2]);
            chk("R4", $sformatf("vblank line %0d", i % 11), vblank_o, EXP_TBL[i % 11][1]);
            chk("R5", $sformatf("field line %0d", i % 11), field_o, EXP_TBL[i % 11][0]);
        end

        // R7: mid-frame polarity write, no effect until boundary (line 10)
        wr(4'd10, 11'd7);
        repeat (3) @(negedge clk);
        chk("R7", "vsync held", vsync_o, 1'b1);
        chk("R7", "vblank held", vblank_o, 1'b1);
        chk("R7", "field held", field_o, 1'b0);
        pulse(1); // line 0, all inverted
        chk("R3", "vsync active-high idle", vsync_o, 1'b0);
        chk("R4", "vblank inverted", vblank_o, 1'b0);
        chk("R5", "field inverted f2", field_o, 1'b1);
        pulse(1); // line 1
        chk("R3", "vsync active-high pulse", vsync_o, 1'b1);
        chk("R5", "field inverted f1", field_o, 1'b0);

        // R6: progressive, lock off, polarity default
        wr(4'd9, 11'd0); wr(4'd10, 11'd0);
        pulse(10); // line 0
        pulse(1);  // line 1
        chk("R6", "vsync line1", vsync_o, 1'b0);
        chk("R6", "field line1", field_o, 1'b0);
        ref_edge(); // R9: would load 3 if honoured
        chk("R9", "ref ignored vsync", vsync_o, 1'b0);
        pulse(2); // line 3
        chk("R9", "line after ignored ref", vblank_o, 1'b0);
        pulse(3); // line 6
        chk("R6", "no second vsync", vsync_o, 1'b1);
        chk("R6", "field low line6", field_o, 1'b0);
        pulse(2); // line 8
        chk("R6", "no second window", vblank_o, 1'b1);

        // R8/R10: interlaced and locked
        wr(4'd9, 11'd3);
        pulse(3); // line 0, lock active
        ref_edge(); // load 14 mod 11 = 3
        chk("R8", "vsync at line3", vsync_o, 1'b1);
        chk("R8", "vblank at line3", vblank_o, 1'b0);
        chk("R10", "lost cleared by ref", lock_lost_o, 1'b0);
        pulse(3); // line 6
        chk("R8", "vsync at line6", vsync_o, 1'b0);
        chk("R8", "field at line6", field_o, 1'b0);
        pulse(8); // 11 lines since ref
        chk("R10", "lost at TOTAL lines", lock_lost_o, 1'b0);
        chk("R2", "wrapped to line3 vblank", vblank_o, 1'b0);
        pulse(1); // 12 lines since ref
        chk("R10", "lost past TOTAL", lock_lost_o, 1'b1);
        ref_edge();
        chk("R10", "lost cleared", lock_lost_o, 1'b0);
        chk("R8", "reload line3", vsync_o, 1'b1);

        finished = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule